// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces one interrupt per port for a memory shared by two ports, the left port and the right port. Each port signals the other by using one reserved location at the top of the address space. The left port posts to the all-ones address. The right port posts to the address one below it. A write by a port to its own posting address raises the interrupt of the opposite port. That interrupt then stays asserted until the flagged port reads the same location. The storage array is not part of this block. Only the access strobes of each port are observed.

Each port presents two chip enables, a read/write strobe, active-low byte enables and an address. An access counts only when the first chip enable is low and the second is high. Both ports run on one shared clock. Each interrupt output is active low and registered. It changes on the clock edge that samples the access. Output enable has no part in setting or clearing a flag, so the block has no output-enable input.

Top module: `mbx_irq`

## Requirements
- R1: While reset is asserted, and on the first edge after its release, `l_irq_n` and `r_irq_n` are both 1.
- R2: A port is enabled only when its `ce0_n` is 0 and its `ce1` is 1. Any other chip-enable combination leaves both interrupts unchanged.
- R3: An enabled left write (`l_rw`=0) to address all-ones (2^AW-1) with at least one `l_be_n` bit at 0 drives `r_irq_n` to 0 after that clock edge.
- R4: An enabled right write (`r_rw`=0) to address 2^AW-2 with at least one `r_be_n` bit at 0 drives `l_irq_n` to 0 after that clock edge.
- R5: An enabled right read (`r_rw`=1) of address 2^AW-1 returns `r_irq_n` to 1 after that edge, whatever the byte enables are.
- R6: An enabled left read (`l_rw`=1) of address 2^AW-2 returns `l_irq_n` to 1 after that edge, whatever the byte enables are.
- R7: A write with every byte-enable bit at 1 neither sets nor clears any interrupt.
- R8: If the set and the clear of one interrupt fall in the same cycle, the interrupt is driven to 0.
- R9: Accesses to any other address, and accesses in the wrong direction to a mailbox address, leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left direction: 1 read, 0 write |
| l_be_n | input | BW | Left byte enables, active low |
| l_addr | input | AW | Left address |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right direction: 1 read, 0 write |
| r_be_n | input | BW | Right byte enables, active low |
| r_addr | input | AW | Right address |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Each flag is a single register that drives its output directly, so a wrong internal state appears on the interrupt pin one edge after the access that caused it. The fault is visible there at once and stays visible until a later access overwrites it. A decoder that picks the wrong address, direction or enable condition therefore shows up as an interrupt that fails to move or moves when it should not. A wrong priority between set and clear shows up only in the cycle where both ports hit the mailbox together, so the bench sweeps every pairing of mailbox accesses on the two ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic { PORT_L = 1'b0, PORT_R = 1'b1 } mbx_port_e;

  // Location a port writes to signal its peer.
  function automatic logic [31:0] mbx_post_addr(input int aw, input mbx_port_e p);
    logic [31:0] top;
    top = (32'd1 << aw) - 32'd1;
    return (p == PORT_L) ? top : top - 32'd1;
  endfunction

  // Location a port reads to release its own interrupt: the peer's post address.
  function automatic logic [31:0] mbx_ack_addr(input int aw, input mbx_port_e p);
    return mbx_post_addr(aw, (p == PORT_L) ? PORT_R : PORT_L);
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int AW = 18,
  parameter int BW = 2,
  parameter logic [AW-1:0] POST_ADDR = '1,
  parameter logic [AW-1:0] ACK_ADDR  = '1
) (
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          rw,
  input  logic [BW-1:0] be_n,
  input  logic [AW-1:0] addr,
  output logic          post,
  output logic          ack
);
  logic enabled;
  logic any_byte;

  always_comb begin
    enabled  = !ce0_n && ce1;
    any_byte = (be_n != {BW{1'b1}});
    post     = enabled && !rw && any_byte && (addr == POST_ADDR);
    ack      = enabled && rw && (addr == ACK_ADDR);
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (set)    pending <= 1'b1;
    else if (clr)    pending <= 1'b0;
  end

  assign irq_n = !pending;

  AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n) set |=> !irq_n); // R8
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (clr && !set) |=> irq_n); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!set && !clr) |=> $stable(irq_n)); // R9
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int AW = 18,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_ce0_n,
  input  logic          l_ce1,
  input  logic          l_rw,
  input  logic [BW-1:0] l_be_n,
  input  logic [AW-1:0] l_addr,
  output logic          l_irq_n,
  input  logic          r_ce0_n,
  input  logic          r_ce1,
  input  logic          r_rw,
  input  logic [BW-1:0] r_be_n,
  input  logic [AW-1:0] r_addr,
  output logic          r_irq_n
);
  import mbx_pkg::*;

  localparam int NP = 2;

  logic          ce0_n_a [NP];
  logic          ce1_a   [NP];
  logic          rw_a    [NP];
  logic [BW-1:0] be_n_a  [NP];
  logic [AW-1:0] addr_a  [NP];
  logic          post_a  [NP];
  logic          ack_a   [NP];
  logic          irq_n_a [NP];

  always_comb begin
    ce0_n_a[0] = l_ce0_n; ce1_a[0] = l_ce1; rw_a[0] = l_rw; be_n_a[0] = l_be_n; addr_a[0] = l_addr;
    ce0_n_a[1] = r_ce0_n; ce1_a[1] = r_ce1; rw_a[1] = r_rw; be_n_a[1] = r_be_n; addr_a[1] = r_addr;
  end

  for (genvar gp = 0; gp < NP; gp++) begin : g_port
    localparam mbx_port_e PID = (gp == 0) ? PORT_L : PORT_R;
    localparam logic [31:0] POST32 = mbx_post_addr(AW, PID);
    localparam logic [31:0] ACK32  = mbx_ack_addr(AW, PID);

    mbx_port_decode #(
      .AW(AW), .BW(BW),
      .POST_ADDR(POST32[AW-1:0]),
      .ACK_ADDR(ACK32[AW-1:0])
    ) u_dec (
      .ce0_n(ce0_n_a[gp]), .ce1(ce1_a[gp]), .rw(rw_a[gp]),
      .be_n(be_n_a[gp]), .addr(addr_a[gp]),
      .post(post_a[gp]), .ack(ack_a[gp])
    );

    // A port's flag is set by the peer's post and cleared by its own ack.
    mbx_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(post_a[NP-1-gp]), .clr(ack_a[gp]),
      .irq_n(irq_n_a[gp])
    );
  end

  assign l_irq_n = irq_n_a[0];
  assign r_irq_n = irq_n_a[1];

  // Named internal events for the checks below.
  logic l_post, r_post, l_ack, r_ack;
  assign l_post = post_a[0];
  assign r_post = post_a[1];
  assign l_ack  = ack_a[0];
  assign r_ack  = ack_a[1];

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n)); // R1
  AST_LEFT_POST_SETS_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) l_post |=> !r_irq_n); // R3
  AST_RIGHT_POST_SETS_LEFT: assert property (@(posedge clk) disable iff (!rst_n) r_post |=> !l_irq_n); // R4
  AST_LEFT_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (l_ack && !r_post) |=> l_irq_n); // R6
  AST_RIGHT_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (r_ack && !l_post) |=> r_irq_n); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_ce0_n || !l_ce1) && (r_ce0_n || !r_ce1)) |=> ($stable(l_irq_n) && $stable(r_irq_n))); // R2
endmodule

// File: tb/sim_mbx_irq.sv
module sim_mbx_irq;
  localparam int AW = 4;
  localparam int BW = 2;
  localparam logic [AW-1:0] TOP = (1 << AW) - 1;
  localparam logic [AW-1:0] NXT = (1 << AW) - 2;

  logic clk = 0;
  logic rst_n = 0;
  logic l_ce0_n = 1, l_ce1 = 0, l_rw = 1, r_ce0_n = 1, r_ce1 = 0, r_rw = 1;
  logic [BW-1:0] l_be_n = '1, r_be_n = '1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_irq_n, r_irq_n;
  int n_run = 0, n_fail = 0;
  logic exp_l = 0, exp_r = 0; // pending flags in the bench model

  always #10 clk = ~clk;

  mbx_irq #(.AW(AW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_ce0_n(l_ce0_n), .l_ce1(l_ce1), .l_rw(l_rw), .l_be_n(l_be_n), .l_addr(l_addr), .l_irq_n(l_irq_n),
    .r_ce0_n(r_ce0_n), .r_ce1(r_ce1), .r_rw(r_rw), .r_be_n(r_be_n), .r_addr(r_addr), .r_irq_n(r_irq_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // One access per port in one cycle; the model decides, then both outputs are checked.
  task automatic cyc(input logic [AW+4:0] lv, input logic [AW+4:0] rv, input string tag_l, input string tag_r);
    logic lp, la, rp, ra, le, re;
    @(negedge clk);
    {l_ce0_n, l_ce1, l_rw, l_be_n, l_addr} = lv;
    {r_ce0_n, r_ce1, r_rw, r_be_n, r_addr} = rv;
    le = (l_ce0_n == 0) && (l_ce1 == 1);
    re = (r_ce0_n == 0) && (r_ce1 == 1);
    lp = le && !l_rw && (l_be_n != 2'b11) && (l_addr == TOP);
    la = le && l_rw && (l_addr == NXT);
    rp = re && !r_rw && (r_be_n != 2'b11) && (r_addr == NXT);
    ra = re && r_rw && (r_addr == TOP);
    exp_r = lp ? 1'b1 : (ra ? 1'b0 : exp_r);
    exp_l = rp ? 1'b1 : (la ? 1'b0 : exp_l);
    @(negedge clk);
    chk(tag_l, l_irq_n, !exp_l);
    chk(tag_r, r_irq_n, !exp_r);
  endtask

  function automatic string tag_of(input logic s, input logic c, input string ts, input string tc);
    return (s && c) ? "R8" : s ? ts : c ? tc : "R9";
  endfunction

  localparam logic [AW+4:0] IDLE = {1'b1, 1'b0, 1'b1, 2'b11, {AW{1'b0}}};

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 left", l_irq_n, 1'b1);
    chk("R1 right", r_irq_n, 1'b1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 left after release", l_irq_n, 1'b1);
    chk("R1 right after release", r_irq_n, 1'b1);

    // R2: left write to TOP with each disabled chip-enable combination
    cyc({1'b1, 1'b1, 1'b0, 2'b00, TOP}, IDLE, "R2", "R2");
    cyc({1'b0, 1'b0, 1'b0, 2'b00, TOP}, IDLE, "R2", "R2");
    cyc({1'b1, 1'b0, 1'b0, 2'b00, TOP}, IDLE, "R2", "R2");
    // R7: no byte enabled
    cyc({1'b0, 1'b1, 1'b0, 2'b11, TOP}, IDLE, "R7", "R7");
    cyc(IDLE, {1'b0, 1'b1, 1'b0, 2'b11, NXT}, "R7", "R7");
    // R3 / R4 set, then R5 / R6 clear (byte enables off on reads)
    cyc({1'b0, 1'b1, 1'b0, 2'b10, TOP}, IDLE, "R3", "R3");
    cyc(IDLE, {1'b0, 1'b1, 1'b0, 2'b01, NXT}, "R4", "R4");
    cyc(IDLE, {1'b0, 1'b1, 1'b1, 2'b11, TOP}, "R5", "R5");
    cyc({1'b0, 1'b1, 1'b1, 2'b11, NXT}, IDLE, "R6", "R6");
    // R8: set and clear of the right flag together
    cyc({1'b0, 1'b1, 1'b0, 2'b00, TOP}, {1'b0, 1'b1, 1'b1, 2'b00, TOP}, "R8", "R8");

    // Exhaustive cross of all mailbox-address accesses on both ports
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 64; j++) begin
        logic [AW+4:0] lv, rv;
        logic [5:0] ii, jj;
        ii = i[5:0];
        jj = j[5:0];
        lv = {ii[5:1], {(AW-1){1'b1}}, ii[0]};
        rv = {jj[5:1], {(AW-1){1'b1}}, jj[0]};
        cyc(lv, rv, "R3/R4/R5/R6 sweep", "R3/R4/R5/R6 sweep");
      end
    end

    // R9: every other address with every control pattern on the left,
    // paired with varied right accesses
    for (int k = 0; k < (1 << (AW + 5)); k++) begin
      logic [AW+4:0] lv, rv;
      logic lp, ra;
      lv = k[AW+4:0];
      rv = (k * 37 + 11) % (1 << (AW + 5));
      lp = !lv[AW+4] && lv[AW+3] && !lv[AW+2] && (lv[AW+1:AW] != 2'b11) && (lv[AW-1:0] == TOP);
      ra = !rv[AW+4] && rv[AW+3] && rv[AW+2] && (rv[AW-1:0] == TOP);
      cyc(lv, rv, "R9 left", tag_of(lp, ra, "R3", "R5"));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule